// File: doc/BRIEF.md
# Receive Data-Word Capture with Idle-Pattern Substitution

This block sits in a serial receive path, between the descrambler and a slope-delta audio decoder. An external detector raises a one-bit-clock pulse when it recognises a data code word in the stream. The block then captures the data word that follows into a register the host can read, and sets a status flag. For the whole capture window, the decoder does not see the received bits. It sees an alternating 1-0 idle pattern instead, which produces the quietest possible analog output. The window lasts 32, 40 or 48 bit clocks, and a control input selects the length. When the window ends, the decoder is fed the descrambled stream again.

The host clears the status flag by pulsing a read strobe. One control input bypasses the whole detect path. Another forces the idle pattern onto the decoder input at any time. Bit timing comes from a one-cycle bit-clock enable within the system clock domain. The decoder output is registered and changes only on those enable cycles.

Top module: `rx_word_capture`

## Requirements
- R1: A detect pulse that is accepted on a bit clock starts a substitution window on the next bit clock. The window is 32 bit clocks for `len_sel`=00, 40 for 01, and 48 for 10 or 11.
- R2: A substitution window never lasts more than 48 bit clocks.
- R3: The first WORD_W received bits of the window are captured, the earliest bit going to the MSB. On the last bit clock of the window they are loaded into `word_q`, and `status` rises at the same edge.
- R4: A `rd_stb` pulse that does not coincide with a load clears `status` on the next clock edge. It leaves `word_q` unchanged.
- R5: Outside substitution and forcing, `dec_bit` takes the value of `rx_bit` at each bit clock. This includes the bit clock that carries the detect pulse and the bit clock just after a window ends.
- R6: While `bypass` is 1, detect pulses are ignored. `dec_bit` keeps following `rx_bit`, and `status` stays 0.
- R7: While `force_idle` is 1, `dec_bit` carries the idle pattern on every bit clock, whether or not a window is running.
- R8: The idle pattern emits 1 on the first idle bit clock and inverts on every further idle bit clock.
- R9: A detect pulse that arrives during a running window is ignored. The window keeps its original length.
- R10: If `rd_stb` is asserted in the same cycle as a word load, `status` stays 1.
- R11: After reset, `status`, `word_q` and `dec_bit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-clock enable, one cycle per bit |
| rx_bit | input | 1 | Descrambled receive bit |
| detect | input | 1 | Code-word-detect pulse, sampled with bit_en |
| rd_stb | input | 1 | Host read strobe for the data register |
| bypass | input | 1 | 1 = ignore detect pulses |
| force_idle | input | 1 | 1 = drive the idle pattern to the decoder |
| len_sel | input | 2 | Window length: 00=32, 01=40, 1x=48 |
| dec_bit | output | 1 | Serial bit to the decoder |
| word_q | output | WORD_W | Captured data word |
| status | output | 1 | Word-ready flag |

## Verification
The case that is hardest to reach from the ports is a read strobe that lands exactly on the bit clock that loads the word. This is only one system cycle out of a window of 32 to 48 bit clocks. The bench counts bit clocks from the detect pulse and raises the strobe together with the bit enable on the final window bit. It sweeps every length code against several words with edge values, and in some of those runs it also injects a second detect pulse in the middle of the window.

// File: rtl/rxcap_pkg.sv
package rxcap_pkg;
  typedef enum logic [1:0] {
    LEN_SHORT = 2'b00,
    LEN_MID   = 2'b01,
    LEN_LONG  = 2'b10,
    LEN_LONG2 = 2'b11
  } len_sel_t;

  function automatic int unsigned window_len(input logic [1:0] sel,
                                             input int unsigned base,
                                             input int unsigned step);
    case (sel)
      LEN_SHORT: window_len = base;
      LEN_MID:   window_len = base + step;
      default:   window_len = base + 2 * step;
    endcase
  endfunction
endpackage

// File: rtl/rxcap_ctl.sv
module rxcap_ctl #(
  parameter int unsigned WORD_W   = 16,
  parameter int unsigned BASE_LEN = 32,
  parameter int unsigned LEN_STEP = 8,
  localparam int unsigned MAX_LEN = BASE_LEN + 2 * LEN_STEP,
  localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_en,
  input  logic       detect,
  input  logic       bypass,
  input  logic [1:0] len_sel,
  output logic       busy,
  output logic       cap_en,
  output logic       load
);
  import rxcap_pkg::*;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last_q;
  logic             start;

  assign start  = bit_en && detect && !bypass && !busy;
  assign cap_en = bit_en && busy && (cnt < CNT_W'(WORD_W));
  assign load   = bit_en && busy && (cnt == last_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      cnt    <= '0;
      last_q <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      cnt    <= '0;
      last_q <= CNT_W'(window_len(len_sel, BASE_LEN, LEN_STEP) - 1);
    end else if (bit_en && busy) begin
      if (load) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt < CNT_W'(MAX_LEN))); // R2

  AST_BYPASS_IDLE: assert property (@(posedge clk) disable iff (rst)
    (bypass && !busy) |=> !busy); // R6

  AST_DETECT_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && bit_en && !load) |=> (busy && cnt == $past(cnt) + 1'b1)); // R9
endmodule

// File: rtl/rxcap_shifter.sv
module rxcap_shifter #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_bit,
  input  logic              cap_en,
  input  logic              load,
  input  logic              rd_stb,
  output logic [WORD_W-1:0] word_q,
  output logic              status
);
  logic [WORD_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
    end else if (cap_en) begin
      shreg <= {shreg[WORD_W-2:0], rx_bit};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      status <= 1'b0;
    end else if (load) begin
      word_q <= shreg;
      status <= 1'b1;
    end else if (rd_stb) begin
      status <= 1'b0;
    end
  end

  AST_STATUS_FROM_LOAD: assert property (@(posedge clk) disable iff (rst)
    $rose(status) |-> $past(load)); // R3

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !load) |=> !status); // R4

  AST_READ_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && load) |=> status); // R10

  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(word_q)); // R4
endmodule

// File: rtl/rxcap_idle_mux.sv
module rxcap_idle_mux (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic rx_bit,
  input  logic busy,
  input  logic force_idle,
  output logic dec_bit
);
  logic idle_sel;
  logic phase;

  assign idle_sel = busy || force_idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_bit <= 1'b0;
      phase   <= 1'b1;
    end else if (bit_en) begin
      dec_bit <= idle_sel ? phase : rx_bit;
      phase   <= idle_sel ? ~phase : 1'b1;
    end
  end

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
    (bit_en && !busy && !force_idle) |=> (dec_bit == $past(rx_bit))); // R5
endmodule

// File: rtl/rx_word_capture.sv
module rx_word_capture #(
  parameter int unsigned WORD_W   = 16,
  parameter int unsigned BASE_LEN = 32,
  parameter int unsigned LEN_STEP = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              rx_bit,
  input  logic              detect,
  input  logic              rd_stb,
  input  logic              bypass,
  input  logic              force_idle,
  input  logic [1:0]        len_sel,
  output logic              dec_bit,
  output logic [WORD_W-1:0] word_q,
  output logic              status
);
  logic busy;
  logic cap_en;
  logic load;

  rxcap_ctl #(
    .WORD_W  (WORD_W),
    .BASE_LEN(BASE_LEN),
    .LEN_STEP(LEN_STEP)
  ) u_ctl (
    .clk    (clk),
    .rst    (rst),
    .bit_en (bit_en),
    .detect (detect),
    .bypass (bypass),
    .len_sel(len_sel),
    .busy   (busy),
    .cap_en (cap_en),
    .load   (load)
  );

  rxcap_shifter #(
    .WORD_W(WORD_W)
  ) u_shift (
    .clk   (clk),
    .rst   (rst),
    .rx_bit(rx_bit),
    .cap_en(cap_en),
    .load  (load),
    .rd_stb(rd_stb),
    .word_q(word_q),
    .status(status)
  );

  rxcap_idle_mux u_mux (
    .clk       (clk),
    .rst       (rst),
    .bit_en    (bit_en),
    .rx_bit    (rx_bit),
    .busy      (busy),
    .force_idle(force_idle),
    .dec_bit   (dec_bit)
  );

  AST_LOAD_ENDS_WINDOW: assert property (@(posedge clk) disable iff (rst)
    $rose(status) |-> !busy); // R5
endmodule

// File: tb/rx_word_capture_test.sv
module rx_word_capture_test;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0;
  logic rx_bit = 1'b0;
  logic detect = 1'b0;
  logic rd_stb = 1'b0;
  logic bypass = 1'b0;
  logic force_idle = 1'b0;
  logic [1:0] len_sel = 2'b00;
  logic dec_bit;
  logic [W-1:0] word_q;
  logic status;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  rx_word_capture #(.WORD_W(W)) uut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .rx_bit(rx_bit),
    .detect(detect), .rd_stb(rd_stb), .bypass(bypass),
    .force_idle(force_idle), .len_sel(len_sel),
    .dec_bit(dec_bit), .word_q(word_q), .status(status)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic next_rx();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic send_bit(input logic b, input logic det, input logic rd);
    @(negedge clk);
    rx_bit = b; detect = det; rd_stb = rd; bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0; detect = 1'b0; rd_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic host_read();
    @(negedge clk);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic run_window(input logic [1:0] sel, input logic [W-1:0] word,
                            input bit det_mid, input bit rd_on_load);
    int n;
    logic b;
    logic [W-1:0] prev_word;
    n = (sel == 2'b00) ? 32 : (sel == 2'b01) ? 40 : 48;
    len_sel = sel;
    prev_word = word_q;
    b = next_rx();
    send_bit(b, 1'b1, 1'b0);
    chk(dec_bit == b, "R5 detect bit passes", dec_bit, b);
    for (int k = 0; k < n; k++) begin
      b = (k < W) ? word[W-1-k] : next_rx();
      send_bit(b, det_mid && (k == 5 || k == n - 3), rd_on_load && (k == n - 1));
      chk(dec_bit == ((k % 2) == 0), "R1 R8 idle pattern", dec_bit, (k % 2) == 0);
      if (k < n - 1)
        chk(status == 1'b0 && word_q == prev_word, "R3 no early load", status, 0);
    end
    chk(status == 1'b1, rd_on_load ? "R10 read on load keeps status" : "R3 status set",
        status, 1);
    chk(word_q == word, "R3 captured word", word_q, word);
    for (int k = 0; k < 3; k++) begin
      b = next_rx();
      send_bit(b, 1'b0, 1'b0);
      chk(dec_bit == b, det_mid ? "R9 R2 window length" : "R5 R2 return to rx", dec_bit, b);
    end
    host_read();
    @(negedge clk);
    chk(status == 1'b0, "R4 read clears status", status, 0);
    chk(word_q == word, "R4 read keeps word", word_q, word);
  endtask

  initial begin
    logic b;
    logic [W-1:0] words [4];
    words[0] = 16'hA5C3; words[1] = 16'h0001; words[2] = 16'h8000; words[3] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(status == 1'b0, "R11 reset status", status, 0);
    chk(word_q == '0, "R11 reset word", word_q, 0);
    chk(dec_bit == 1'b0, "R11 reset dec_bit", dec_bit, 0);

    for (int i = 0; i < 4; i++) begin
      b = next_rx();
      send_bit(b, 1'b0, 1'b0);
      chk(dec_bit == b, "R5 pass-through", dec_bit, b);
    end

    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 4; w++)
        run_window(2'(s), words[w], (w == 1), (w == 2));

    bypass = 1'b1;
    for (int i = 0; i < 50; i++) begin
      b = next_rx();
      send_bit(b, (i % 7) == 0, 1'b0);
      chk(dec_bit == b && status == 1'b0, "R6 bypass ignores detect", dec_bit, b);
    end
    bypass = 1'b0;

    force_idle = 1'b1;
    for (int i = 0; i < 10; i++) begin
      send_bit(next_rx(), 1'b0, 1'b0);
      chk(dec_bit == ((i % 2) == 0), "R7 R8 forced idle", dec_bit, (i % 2) == 0);
    end
    force_idle = 1'b0;
    b = next_rx();
    send_bit(b, 1'b0, 1'b0);
    chk(dec_bit == b, "R7 force released", dec_bit, b);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule